// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the digital register front end of a two-channel 12-bit converter that is written from an 8-bit parallel bus. Each channel owns a two-part input register (an 8-bit low byte and a 4-bit high nibble) and a converter register that holds the code being converted. The host fills the input registers a part at a time. A single update strobe then moves both channels into their converter registers in the same clock cycle, so the two analog outputs change together.

The bus strobes are asynchronous and active low: chip select `cs_n`, write `wr_n`, update `upd_n` and clear `clr_n`. The block passes them, together with the address and data, through a `SYNC_STAGES` flop pipeline into the `clk` domain. A write takes effect when the block sees its trailing (rising) edge. The address, data, chip select and update values used are the ones sampled in the last synchronised cycle in which write was still low.

A control FSM sequences the work. It has three states:
- `ST_IDLE`: waiting for a write.
- `ST_ARMED`: write is low and the bus fields are being captured.
- `ST_CLEAR`: clear is being held.

It has these transitions:
- IDLE→ARMED when write goes low.
- ARMED→IDLE when write is released; this is the commit cycle.
- IDLE/ARMED→CLEAR when clear is seen.
- CLEAR→IDLE only once both clear and write are released.

Top module: `dual_dac_regif`

## Requirements
- R1: After reset all four register outputs (`dac_a`, `dac_b`, `inreg_a`, `inreg_b`) read zero.
- R2: A committed write with chip select low decodes `addr` as {channel, part}. 00 loads channel A bits 7..0 from `data[7:0]`. 01 loads channel A bits 11..8 from `data[3:0]`. 10 and 11 do the same for channel B. Bits 7..4 of the bus are ignored on nibble loads.
- R3: Loading one part of an input register leaves the other part of that register, and the other channel's register, unchanged.
- R4: A write with chip select low and update high changes no converter register.
- R5: A write with update low and chip select high copies both input registers into both converter registers in the same cycle. It loads no input register, whatever `addr` and `data` hold.
- R6: A write with chip select and update both low is transparent. The selected input register part is loaded, and in the same cycle both converter registers take the new input register contents.
- R7: Clear low zeroes every input and converter register, whatever the other strobes do. A write that is pending when clear arrives is discarded.
- R8: No register changes while write stays high, whatever the other inputs do. A write pulse with both chip select and update high also changes nothing.
- R9: The address and data used by a write are those present while write is low. Changing them after write is released has no effect. The result is visible within `SYNC_STAGES`+2 clock cycles of the release.
- R10: A write pulse that overlaps a held clear in any way has no effect, even if it ends after clear is released. The next write after both strobes are released works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; committed on its rising edge |
| upd_n | input | 1 | Update strobe, active low; transfers both channels |
| clr_n | input | 1 | Clear strobe, active low; zeroes all registers |
| addr | input | 2 | Target select: bit 1 channel (0 = A, 1 = B), bit 0 part (0 = low byte, 1 = high nibble) |
| data | input | BUS_W | Parallel data bus |
| dac_a | output | RES_W | Channel A converter register |
| dac_b | output | RES_W | Channel B converter register |
| inreg_a | output | RES_W | Channel A input register {high nibble, low byte} |
| inreg_b | output | RES_W | Channel B input register {high nibble, low byte} |

## Verification
The bench builds the block with its defaults: RES_W = 12, BUS_W = 8 and SYNC_STAGES = 2. With these values the high part is a 4-bit nibble, so a nibble load whose bus carries ones in bits 7..4 shows that those bits are dropped. The two-stage pipeline gives a commit delay short enough that the bench can scramble the bus one cycle after releasing write and still see the values from the strobe window. The same delay lets the bench overlap clear and write in both orders and show that neither overlap leaks a load.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    // Number of converter channels; the address MSB selects between them.
    localparam int unsigned NUM_CH = 2;

    // Control sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CLEAR = 2'd2
    } ctl_state_e;

    // Address LSB: which part of an input register is written.
    typedef enum logic {
        PART_LOW  = 1'b0,
        PART_HIGH = 1'b1
    } part_e;

endpackage

// File: rtl/dacif_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous bus inputs.
// All bits travel through the same number of flops so they stay aligned.
module dacif_sync #(
    parameter int unsigned      WIDTH   = 8,
    parameter int unsigned      STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/dacif_ctrl.sv
// Control sequencer: captures bus fields while write is held and issues
// a one-cycle commit (part load and/or transfer) when write is released.
module dacif_ctrl
    import dacif_pkg::*;
#(
    parameter int unsigned BUS_W  = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_act,
    input  logic                   wr_act,
    input  logic                   cs_act,
    input  logic                   upd_act,
    input  logic [ADDR_W-1:0]      addr_s,
    input  logic [BUS_W-1:0]       data_s,
    output logic                   clr_o,
    output logic [(1<<ADDR_W)-1:0] ld_en,
    output logic                   xfer_o,
    output logic [BUS_W-1:0]       data_o
);

    localparam int unsigned NUM_TGT = 1 << ADDR_W;

    ctl_state_e state_q, state_d;

    logic              cap_cs_q;
    logic              cap_upd_q;
    logic [ADDR_W-1:0] cap_addr_q;
    logic [BUS_W-1:0]  cap_data_q;
    logic              commit;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clr_act)     state_d = ST_CLEAR;
                else if (wr_act) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (clr_act)      state_d = ST_CLEAR;
                else if (!wr_act) state_d = ST_IDLE;
            end
            ST_CLEAR: begin
                if (!clr_act && !wr_act) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Field capture while the write strobe is held (outside clear)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_cs_q   <= 1'b0;
            cap_upd_q  <= 1'b0;
            cap_addr_q <= '0;
            cap_data_q <= '0;
        end else if (wr_act && !clr_act && state_q != ST_CLEAR) begin
            cap_cs_q   <= cs_act;
            cap_upd_q  <= upd_act;
            cap_addr_q <= addr_s;
            cap_data_q <= data_s;
        end
    end

    // Output decode
    always_comb begin
        commit = (state_q == ST_ARMED) && !wr_act && !clr_act;
        ld_en  = '0;
        if (commit && cap_cs_q) ld_en[cap_addr_q] = 1'b1;
        xfer_o = commit && cap_upd_q;
        clr_o  = clr_act;
        data_o = cap_data_q;
    end

    // At most one register part is loaded per commit.
    p_single_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_en));

    // Clear is entered the cycle after it is seen.
    p_clear_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (state_q == ST_CLEAR));

    // Nothing commits while clear is in force or its write is draining.
    p_clear_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |-> (ld_en == '0 && !xfer_o));

    // Write inactive from idle: no action in the following cycle.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wr_act) |=> (ld_en == '0 && !xfer_o));

    initial begin
        assert (NUM_TGT == 2 * NUM_CH) else $error("address must cover two parts per channel");
    end

endmodule

// File: rtl/dacif_chan.sv
// One converter channel: two-part input register plus converter register.
module dacif_chan #(
    parameter int unsigned RES_W = 12,
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic             xfer,
    input  logic [BUS_W-1:0] data,
    output logic [RES_W-1:0] in_word,
    output logic [RES_W-1:0] dac_word
);

    localparam int unsigned HI_W = RES_W - BUS_W;

    logic [BUS_W-1:0] lo_q, lo_d;
    logic [HI_W-1:0]  hi_q, hi_d;
    logic [RES_W-1:0] dac_q;

    always_comb begin
        lo_d = ld_lo ? data : lo_q;
        hi_d = ld_hi ? data[HI_W-1:0] : hi_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            dac_q <= '0;
        end else if (clr) begin
            lo_q  <= '0;
            hi_q  <= '0;
            dac_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
            if (xfer) dac_q <= {hi_d, lo_d};
        end
    end

    assign in_word  = {hi_q, lo_q};
    assign dac_word = dac_q;

    p_hold_dac_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !xfer) |=> $stable(dac_word));

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dac_word == '0 && in_word == '0));

    p_keep_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld_hi) |=> $stable(in_word[RES_W-1:BUS_W]));

    p_keep_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld_lo) |=> $stable(in_word[BUS_W-1:0]));

    p_transparent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && xfer) |=> (dac_word == in_word));

endmodule

// File: rtl/dual_dac_regif.sv
// Top: synchroniser, control sequencer and two converter channels.
module dual_dac_regif
    import dacif_pkg::*;
#(
    parameter int unsigned RES_W       = 12,
    parameter int unsigned BUS_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             upd_n,
    input  logic             clr_n,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] data,
    output logic [RES_W-1:0] dac_a,
    output logic [RES_W-1:0] dac_b,
    output logic [RES_W-1:0] inreg_a,
    output logic [RES_W-1:0] inreg_b
);

    localparam int unsigned ADDR_W = 2;
    localparam int unsigned NUM_TGT = 1 << ADDR_W;
    localparam int unsigned SYNC_W = 4 + ADDR_W + BUS_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1111, {(ADDR_W + BUS_W){1'b0}}};

    logic [SYNC_W-1:0]  sync_in, sync_out;
    logic               clr_act, wr_act, upd_act, cs_act;
    logic [ADDR_W-1:0]  addr_s;
    logic [BUS_W-1:0]   data_s;
    logic               clr_c, xfer_c;
    logic [NUM_TGT-1:0] ld_en;
    logic [BUS_W-1:0]   data_c;
    logic [RES_W-1:0]   in_arr  [NUM_CH];
    logic [RES_W-1:0]   dac_arr [NUM_CH];

    assign sync_in = {clr_n, wr_n, upd_n, cs_n, addr, data};

    dacif_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sync_in),
        .q    (sync_out)
    );

    assign clr_act = ~sync_out[SYNC_W-1];
    assign wr_act  = ~sync_out[SYNC_W-2];
    assign upd_act = ~sync_out[SYNC_W-3];
    assign cs_act  = ~sync_out[SYNC_W-4];
    assign addr_s  = sync_out[BUS_W +: ADDR_W];
    assign data_s  = sync_out[BUS_W-1:0];

    dacif_ctrl #(
        .BUS_W (BUS_W),
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_act(clr_act),
        .wr_act (wr_act),
        .cs_act (cs_act),
        .upd_act(upd_act),
        .addr_s (addr_s),
        .data_s (data_s),
        .clr_o  (clr_c),
        .ld_en  (ld_en),
        .xfer_o (xfer_c),
        .data_o (data_c)
    );

    for (genvar ch = 0; ch < int'(NUM_CH); ch++) begin : g_chan
        dacif_chan #(
            .RES_W(RES_W),
            .BUS_W(BUS_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr_c),
            .ld_lo   (ld_en[2*ch + int'(PART_LOW)]),
            .ld_hi   (ld_en[2*ch + int'(PART_HIGH)]),
            .xfer    (xfer_c),
            .data    (data_c),
            .in_word (in_arr[ch]),
            .dac_word(dac_arr[ch])
        );
    end

    assign inreg_a = in_arr[0];
    assign inreg_b = in_arr[1];
    assign dac_a   = dac_arr[0];
    assign dac_b   = dac_arr[1];

    // Both channels move together on a transfer.
    p_both_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_c && !clr_c) |=> (dac_a == inreg_a && dac_b == inreg_b));

    // Converter outputs only change on a transfer or a clear.
    p_dac_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_c && !clr_c) |=> ($stable(dac_a) && $stable(dac_b)));

endmodule

// File: tb/test_dual_dac_regif.sv
module test_dual_dac_regif;

    localparam int RES_W = 12;
    localparam int BUS_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1, clr_n = 1'b1;
    logic [1:0]       addr = 2'b00;
    logic [BUS_W-1:0] data = '0;
    logic [RES_W-1:0] dac_a, dac_b, inreg_a, inreg_b;

    always #5 clk = ~clk;

    dual_dac_regif i_dual_dac_regif (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n),
        .clr_n(clr_n), .addr(addr), .data(data),
        .dac_a(dac_a), .dac_b(dac_b), .inreg_a(inreg_a), .inreg_b(inreg_b)
    );

    typedef struct {
        string      req;
        logic [11:0] ea, eb, ia, ib;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // Reference model state
    logic [7:0]  m_lo  [2];
    logic [3:0]  m_hi  [2];
    logic [11:0] m_dac [2];

    function automatic logic [11:0] m_in(int ch);
        return {m_hi[ch], m_lo[ch]};
    endfunction

    task automatic push_exp(string req);
        exp_t e;
        e.req = req;
        e.ea = m_dac[0]; e.eb = m_dac[1];
        e.ia = m_in(0);  e.ib = m_in(1);
        sb_q.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_one(string req, string nm, logic [11:0] act, logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, nm, act, exp);
        end
    endtask

    // Monitor: pop expected items and compare against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check_one(e.req, "dac_a",   dac_a,   e.ea);
                check_one(e.req, "dac_b",   dac_b,   e.eb);
                check_one(e.req, "inreg_a", inreg_a, e.ia);
                check_one(e.req, "inreg_b", inreg_b, e.ib);
            end
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive one write pulse; scramble the bus right after release.
    task automatic bus_write(bit cs, bit upd, logic [1:0] a, logic [7:0] d, string req);
        @(negedge clk);
        cs_n = ~cs; upd_n = ~upd; addr = a; data = d;
        @(negedge clk);
        wr_n = 1'b0;
        idle(4);
        wr_n = 1'b1;
        @(negedge clk);
        addr = ~a; data = ~d; cs_n = 1'b1; upd_n = 1'b1;   // R9 scramble
        if (cs) begin
            if (a[0] == 1'b0) m_lo[a[1]] = d;
            else              m_hi[a[1]] = d[3:0];
        end
        if (upd) begin
            m_dac[0] = m_in(0);
            m_dac[1] = m_in(1);
        end
        idle(7);
        push_exp(req);
    endtask

    task automatic model_clear();
        for (int c = 0; c < 2; c++) begin
            m_lo[c] = '0; m_hi[c] = '0; m_dac[c] = '0;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        idle(20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        model_clear();
        idle(4);
        rst_n = 1'b1;
        idle(4);
        push_exp("R1 reset");

        bus_write(1, 0, 2'b00, 8'hA5, "R2 R4 A low byte");
        bus_write(1, 0, 2'b01, 8'hFC, "R2 A high nibble drops bus bits 7..4");
        bus_write(1, 0, 2'b10, 8'h5A, "R2 B low byte");
        bus_write(1, 0, 2'b11, 8'h37, "R2 R3 B high nibble");
        bus_write(1, 0, 2'b00, 8'h11, "R3 A low keeps high nibble");
        bus_write(0, 1, 2'b10, 8'hFF, "R5 update only, no input load");
        bus_write(0, 0, 2'b01, 8'h99, "R8 cs and upd high");

        // R8: toggle everything with write high
        @(negedge clk);
        cs_n = 1'b0; upd_n = 1'b0; addr = 2'b11; data = 8'h66;
        idle(3);
        cs_n = 1'b1; addr = 2'b00; data = 8'h12;
        idle(3);
        upd_n = 1'b1;
        idle(6);
        push_exp("R8 write high");

        bus_write(1, 1, 2'b11, 8'h02, "R6 transparent load");
        bus_write(1, 0, 2'b10, 8'hC3, "R9 bus scrambled after release");

        // R7: plain clear pulse
        @(negedge clk);
        clr_n = 1'b0; idle(3); clr_n = 1'b1;
        model_clear();
        idle(7);
        push_exp("R7 clear");

        bus_write(1, 0, 2'b00, 8'h77, "R2 reload after clear");

        // R7: clear arrives while a write is pending
        @(negedge clk);
        cs_n = 1'b0; upd_n = 1'b0; addr = 2'b00; data = 8'h99;
        @(negedge clk); wr_n = 1'b0;
        idle(4); clr_n = 1'b0;
        idle(4); wr_n = 1'b1;
        idle(4); clr_n = 1'b1; cs_n = 1'b1; upd_n = 1'b1;
        model_clear();
        idle(8);
        push_exp("R7 pending write discarded");

        // R10: write starts inside clear and ends after it
        @(negedge clk);
        clr_n = 1'b0; idle(4);
        cs_n = 1'b0; addr = 2'b10; data = 8'h33; wr_n = 1'b0;
        idle(4); clr_n = 1'b1;
        idle(4); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        idle(8);
        push_exp("R10 overlapping write ignored");

        bus_write(1, 0, 2'b10, 8'h44, "R10 recovery write");
        bus_write(1, 1, 2'b01, 8'h0E, "R6 R5 transparent high nibble");

        idle(4);
        done = 1;
        finish_run();
    end

endmodule